// File: doc/BRIEF.md
# Streaming Fixed-Point Dot Product Unit

This block computes the dot product of two vectors of signed fixed-point numbers. The vectors stream in one element pair per accepted transfer. A compile-time mode selects real operands or complex operands. A complex pair is presented as separate real and imaginary buses. The element products are computed in a multiply pipeline whose depth is a parameter. They are summed in a full-precision accumulator that has enough guard bits that it can never wrap.

When the last pair of a vector has passed through the multiplier, the accumulated sum is narrowed to the output format and held in an output register. Narrowing drops `DROP` fraction bits with round-half-away-from-zero and then saturates to `OUT_W` bits. An overflow flag goes high when either component had to be clipped. A downstream ready input freezes the held result. While the result is frozen, the whole datapath stalls and the block refuses new input.

Top module: `dot_stream`

## Requirements
- R1: In complex mode each accepted pair adds xr*yr - xi*yi to the real sum and xr*yi + xi*yr to the imaginary sum, with no conjugation. In real mode only xr*yr is summed, the imaginary output is zero, and the imaginary inputs are ignored.
- R2: A result is emitted once exactly `VLEN` pairs have been accepted. A pair counts only in a cycle where `in_valid` and `in_ready` are both high. With `VLEN` = 1 every accepted pair is a complete result.
- R3: `in_ready` is low exactly in the cycles where `out_valid` is high and `out_ready` is low.
- R4: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with `out_re`, `out_im` and `out_ovf` unchanged.
- R5: A result is consumed when `out_valid` and `out_ready` are both high. Each completed vector produces exactly one result, and results leave in the order their vectors completed.
- R6: Each component is formed from the exact sum by dividing by 2^`DROP` and rounding to the nearest integer, with ties going away from zero. For example, with `DROP` = 4, sums of 8, -8, -24 and 7 give 1, -1, -2 and 0.
- R7: A rounded component above 2^(`OUT_W`-1)-1 or below -2^(`OUT_W`-1) is clipped to that limit. `out_ovf` is the OR of the two components' clip conditions.
- R8: With no downstream stall, `out_valid` rises `MUL_STAGES` clock edges after the edge that accepts the final pair of a vector. The pipeline depth never changes a computed value.
- R9: Synchronous active-high `rst` clears `out_valid`, the element count and the partial sum. Pairs accepted before a reset do not contribute to any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers an element pair |
| in_ready | output | 1 | Block can accept a pair this cycle |
| x_re | input | IN_W | Real part of x element, signed |
| x_im | input | IN_W | Imaginary part of x element, signed (complex mode) |
| y_re | input | IN_W | Real part of y element, signed |
| y_im | input | IN_W | Imaginary part of y element, signed (complex mode) |
| out_ready | input | 1 | Downstream can take the result |
| out_valid | output | 1 | Result buses carry a finished dot product |
| out_re | output | OUT_W | Real part of the result, signed |
| out_im | output | OUT_W | Imaginary part of the result, signed |
| out_ovf | output | 1 | Saturation occurred in either component |

## Verification
The bound checker verifies the following on every cycle:
- input back-pressure while a result is held;
- the freeze of a held result and its flag;
- that a raised overflow flag always comes with a component sitting on a rail;
- that `out_valid` is low when reset releases.

Only the bench scenarios can show the arithmetic. These cover complex products without conjugation, the rounding ties in both signs, clipping at both rails, and element counting across idle input cycles and mid-vector resets. The bench also measures the pipeline latency during stall-free stretches and checks result ordering under random downstream back-pressure.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_CPLX = 1'b1
    } mode_e;

    // guard bits needed so a sum of n terms cannot wrap
    function automatic int guard_bits(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // width of an index that counts 0..n-1 (at least one bit)
    function automatic int count_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dp_mul_pipe.sv
module dp_mul_pipe #(
    parameter int            IN_W   = 8,
    parameter int            STAGES = 2,
    parameter dp_pkg::mode_e MODE   = dp_pkg::MODE_CPLX,
    localparam int           SW     = 2 * IN_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] xr,
    input  logic signed [IN_W-1:0] xi,
    input  logic signed [IN_W-1:0] yr,
    input  logic signed [IN_W-1:0] yi,
    output logic                   p_vld,
    output logic signed [SW-1:0]   p_re,
    output logic signed [SW-1:0]   p_im
);
    logic signed [SW-1:0] xr_e, yr_e, prod_re, prod_im;
    logic signed [SW-1:0] re_q [STAGES];
    logic signed [SW-1:0] im_q [STAGES];
    logic [STAGES-1:0]    vld_q;

    assign xr_e = SW'(xr);
    assign yr_e = SW'(yr);

    generate
        if (MODE == dp_pkg::MODE_CPLX) begin : g_cplx
            logic signed [SW-1:0] xi_e, yi_e;
            assign xi_e    = SW'(xi);
            assign yi_e    = SW'(yi);
            assign prod_re = xr_e * yr_e - xi_e * yi_e;
            assign prod_im = xr_e * yi_e + xi_e * yr_e;
        end else begin : g_real
            assign prod_re = xr_e * yr_e;
            assign prod_im = '0;
        end
    endgenerate

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst)     vld_q[0] <= 1'b0;
                    else if (en) vld_q[0] <= in_vld;
                    if (en) begin
                        re_q[0] <= prod_re;
                        im_q[0] <= prod_im;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst)     vld_q[s] <= 1'b0;
                    else if (en) vld_q[s] <= vld_q[s-1];
                    if (en) begin
                        re_q[s] <= re_q[s-1];
                        im_q[s] <= im_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign p_vld = vld_q[STAGES-1];
    assign p_re  = re_q[STAGES-1];
    assign p_im  = im_q[STAGES-1];
endmodule

// File: rtl/dp_accum.sv
module dp_accum #(
    parameter int  SW   = 17,
    parameter int  AW   = 19,
    parameter int  VLEN = 4,
    localparam int CW   = dp_pkg::count_bits(VLEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 p_vld,
    input  logic signed [SW-1:0] p_re,
    input  logic signed [SW-1:0] p_im,
    output logic                 done,
    output logic signed [AW-1:0] sum_re,
    output logic signed [AW-1:0] sum_im
);
    logic signed [AW-1:0] acc_re, acc_im;
    logic [CW-1:0]        cnt;
    logic                 last;

    assign last   = (cnt == CW'(VLEN - 1));
    assign sum_re = acc_re + AW'(p_re);
    assign sum_im = acc_im + AW'(p_im);
    assign done   = p_vld && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
            cnt    <= '0;
        end else if (en && p_vld) begin
            if (last) begin
                acc_re <= '0;
                acc_im <= '0;
                cnt    <= '0;
            end else begin
                acc_re <= sum_re;
                acc_im <= sum_im;
                cnt    <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dp_narrow.sv
module dp_narrow #(
    parameter int  AW    = 19,
    parameter int  DROP  = 4,
    parameter int  OUT_W = 10,
    localparam int EW    = dp_pkg::max_int(AW + 1, OUT_W + 1)
) (
    input  logic signed [AW-1:0]    sum,
    output logic signed [OUT_W-1:0] res,
    output logic                    ovf
);
    localparam logic signed [EW-1:0] MAXV = EW'((longint'(1) << (OUT_W - 1)) - 1);
    localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

    logic signed [EW-1:0] ext, shifted;

    assign ext = EW'(sum);

    generate
        if (DROP > 0) begin : g_round
            localparam logic signed [EW-1:0] HALF = EW'(longint'(1) << (DROP - 1));
            logic signed [EW-1:0] biased;
            // ties move away from zero: negative sums lose one before the shift
            assign biased  = ext + HALF - EW'({1'b0, sum[AW-1]});
            assign shifted = biased >>> DROP;
        end else begin : g_exact
            assign shifted = ext;
        end
    endgenerate

    always_comb begin
        if (shifted > MAXV) begin
            res = MAXV[OUT_W-1:0];
            ovf = 1'b1;
        end else if (shifted < MINV) begin
            res = MINV[OUT_W-1:0];
            ovf = 1'b1;
        end else begin
            res = shifted[OUT_W-1:0];
            ovf = 1'b0;
        end
    end
endmodule

// File: rtl/dot_stream.sv
module dot_stream #(
    parameter int            IN_W       = 8,
    parameter int            VLEN       = 4,
    parameter int            MUL_STAGES = 2,
    parameter int            DROP       = 4,
    parameter int            OUT_W      = 10,
    parameter dp_pkg::mode_e MODE       = dp_pkg::MODE_CPLX
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  x_re,
    input  logic signed [IN_W-1:0]  x_im,
    input  logic signed [IN_W-1:0]  y_re,
    input  logic signed [IN_W-1:0]  y_im,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_re,
    output logic signed [OUT_W-1:0] out_im,
    output logic                    out_ovf
);
    localparam int SW = 2 * IN_W + 1;
    localparam int AW = SW + dp_pkg::guard_bits(VLEN);

    logic                    adv, p_vld, done, fire, ovf_re, ovf_im;
    logic signed [SW-1:0]    p_re, p_im;
    logic signed [AW-1:0]    sum_re, sum_im;
    logic signed [OUT_W-1:0] n_re, n_im;

    // a held result freezes every stage
    assign adv      = !(out_valid && !out_ready);
    assign in_ready = adv;
    assign fire     = adv && done;

    dp_mul_pipe #(.IN_W(IN_W), .STAGES(MUL_STAGES), .MODE(MODE)) u_mul (
        .clk(clk), .rst(rst), .en(adv), .in_vld(in_valid && adv),
        .xr(x_re), .xi(x_im), .yr(y_re), .yi(y_im),
        .p_vld(p_vld), .p_re(p_re), .p_im(p_im)
    );

    dp_accum #(.SW(SW), .AW(AW), .VLEN(VLEN)) u_acc (
        .clk(clk), .rst(rst), .en(adv), .p_vld(p_vld),
        .p_re(p_re), .p_im(p_im),
        .done(done), .sum_re(sum_re), .sum_im(sum_im)
    );

    dp_narrow #(.AW(AW), .DROP(DROP), .OUT_W(OUT_W)) u_nre (
        .sum(sum_re), .res(n_re), .ovf(ovf_re)
    );

    dp_narrow #(.AW(AW), .DROP(DROP), .OUT_W(OUT_W)) u_nim (
        .sum(sum_im), .res(n_im), .ovf(ovf_im)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            out_ovf   <= 1'b0;
        end else if (adv) begin
            out_valid <= fire;
            if (fire) begin
                out_re  <= n_re;
                out_im  <= n_im;
                out_ovf <= ovf_re || ovf_im;
            end
        end
    end
endmodule

// File: rtl/dot_stream_chk.sv
module dot_stream_chk #(
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_ready,
    input logic                    out_ready,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_re,
    input logic signed [OUT_W-1:0] out_im,
    input logic                    out_ovf
);
    localparam logic signed [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] BOT = {1'b1, {(OUT_W-1){1'b0}}};

    // R3
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R4
    held_result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_ovf)));

    // R7
    ovf_on_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf) |->
            (out_re == TOP || out_re == BOT || out_im == TOP || out_im == BOT));

    // R9
    reset_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
endmodule

bind dot_stream dot_stream_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_ready(out_ready),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_ovf(out_ovf)
);

// File: tb/sim_dot_stream.sv
module sim_dot_stream;
    localparam int IN_W = 8, VLEN = 4, STG = 2, DROP = 4, OUT_W = 10;
    localparam longint OMAX = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint OMIN = -(longint'(1) << (OUT_W - 1));

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
    logic in_ready, out_valid, out_ovf;
    logic signed [IN_W-1:0]  x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic signed [OUT_W-1:0] out_re, out_im;

    always #10 clk = ~clk;

    dot_stream #(.IN_W(IN_W), .VLEN(VLEN), .MUL_STAGES(STG), .DROP(DROP),
                 .OUT_W(OUT_W), .MODE(dp_pkg::MODE_CPLX)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_re(out_re), .out_im(out_im), .out_ovf(out_ovf)
    );

    int checks = 0, errors = 0, cyc = 0;
    longint acc_re = 0, acc_im = 0;
    int cnt = 0;
    longint q_re[$], q_im[$];
    bit q_ovf[$], q_timed[$];
    string q_tag[$];
    int q_due[$];
    string cur_tag = "R1";
    bit rdy_rand = 0, gaps = 0;
    bit held_prev = 0, h_ovf;
    logic signed [OUT_W-1:0] h_re, h_im;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // R6 / R7 reference: round half away from zero, then clip
    task automatic narrow(input longint v, output longint r, output bit o);
        longint half = longint'(1) << (DROP - 1);
        if (v >= 0) r = (v + half) >>> DROP;
        else        r = -((-v + half) >>> DROP);
        o = 0;
        if (r > OMAX) begin r = OMAX; o = 1; end
        if (r < OMIN) begin r = OMIN; o = 1; end
    endtask

    task automatic model_push(input int xr, input int xi, input int yr, input int yi);
        longint r, i;
        bit orr, oi;
        acc_re += longint'(xr * yr - xi * yi);
        acc_im += longint'(xr * yi + xi * yr);
        cnt++;
        if (cnt == VLEN) begin
            narrow(acc_re, r, orr);
            narrow(acc_im, i, oi);
            q_re.push_back(r); q_im.push_back(i); q_ovf.push_back(orr | oi);
            q_tag.push_back(cur_tag); q_due.push_back(cyc + STG + 1);
            q_timed.push_back(!rdy_rand);
            acc_re = 0; acc_im = 0; cnt = 0;
        end
    endtask

    task automatic step(input bit v, input int xr, input int xi, input int yr,
                        input int yi, output bit accepted);
        @(negedge clk);
        if (held_prev) begin
            // R4: held result frozen
            check(out_valid == 1'b1, "R4 valid", out_valid, 1);
            check(out_re == h_re && out_im == h_im && out_ovf == h_ovf,
                  "R4 data", out_re, h_re);
        end
        in_valid  = v;
        x_re = xr[IN_W-1:0]; x_im = xi[IN_W-1:0];
        y_re = yr[IN_W-1:0]; y_im = yi[IN_W-1:0];
        out_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
        #1;
        accepted = in_valid && in_ready;
        // R3
        check(in_ready == !(out_valid && !out_ready), "R3", in_ready,
              !(out_valid && !out_ready));
        if (out_valid && out_ready) begin
            if (q_re.size() == 0) begin
                check(0, "R5 unexpected result", 1, 0);
            end else begin
                string t = q_tag.pop_front();
                int due = q_due.pop_front();
                check(longint'(out_re) == q_re[0], {t, " re"}, out_re, q_re[0]);
                check(longint'(out_im) == q_im[0], {t, " im"}, out_im, q_im[0]);
                check(out_ovf == q_ovf[0], {t, " R7 ovf"}, out_ovf, q_ovf[0]);
                if (q_timed[0]) check(cyc == due, "R8 latency", cyc, due);
                void'(q_re.pop_front()); void'(q_im.pop_front());
                void'(q_ovf.pop_front()); void'(q_timed.pop_front());
            end
        end else if (out_valid && q_re.size() == 0) begin
            check(0, "R2 result before vector complete", 1, 0);
        end
        held_prev = out_valid && !out_ready;
        h_re = out_re; h_im = out_im; h_ovf = out_ovf;
        if (accepted) model_push(xr, xi, yr, yi);
        cyc++;
    endtask

    task automatic send(input int xr, input int xi, input int yr, input int yi);
        bit a;
        if (gaps) begin
            while (($urandom % 3) == 0)
                step(0, $urandom % 256 - 128, 7, -5, 3, a); // R2: idle cycles not counted
        end
        do step(1, xr, xi, yr, yi, a); while (!a);
    endtask

    task automatic vec1(input int xr, input int xi, input int yr, input int yi);
        send(xr, xi, yr, yi);
        for (int k = 1; k < VLEN; k++) send(0, 0, 0, 0);
    endtask

    task automatic drain();
        bit a;
        rdy_rand = 0;
        for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, a);
        check(q_re.size() == 0, "R5 all results delivered", q_re.size(), 0);
    endtask

    initial begin
        bit a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
        check(in_ready == 1'b1, "R3 reset ready", in_ready, 1);
        rst = 1'b0;

        cur_tag = "R1 complex";
        vec1(16, 32, 3, 4);                 // re -80 -> -5, im 160 -> 10
        for (int v = 0; v < 3; v++)
            for (int k = 0; k < VLEN; k++)
                send($urandom % 16 - 8, $urandom % 16 - 8, $urandom % 16 - 8, $urandom % 16 - 8);

        cur_tag = "R6 rounding";
        vec1(2, 0, 4, 0);                   // 8  -> 1
        vec1(-2, 0, 4, 0);                  // -8 -> -1
        vec1(-3, 0, 8, 0);                  // -24 -> -2
        vec1(3, 0, 8, 0);                   // 24 -> 2
        vec1(1, 0, 7, 0);                   // 7  -> 0

        cur_tag = "R7 saturation";
        for (int k = 0; k < VLEN; k++) send(-128, 0, -128, 0);  // re high rail
        for (int k = 0; k < VLEN; k++) send(-128, 0, 127, 0);   // re low rail
        for (int k = 0; k < VLEN; k++) send(-128, 0, 0, -128);  // im high rail
        drain();

        // R9: partial vector discarded by reset
        cur_tag = "R9 after reset";
        send(100, 50, 100, 50);
        send(90, -40, 80, 30);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        held_prev = 0; acc_re = 0; acc_im = 0; cnt = 0;
        vec1(5, 1, 6, 2);
        drain();

        // R2, R4, R5: gaps and random back-pressure
        cur_tag = "R5 stream";
        gaps = 1; rdy_rand = 1;
        for (int v = 0; v < 40; v++)
            for (int k = 0; k < VLEN; k++)
                send($urandom % 256 - 128, $urandom % 256 - 128,
                     $urandom % 256 - 128, $urandom % 256 - 128);
        gaps = 0;
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule